// File: doc/BRIEF.md
# DCT Rebuild and Twiddle Rotate Unit

This unit sits between a DFT engine and the rest of a DCT-via-FFT pipeline. It turns DFT bins into DCT coefficients in the forward direction. It also turns DCT coefficient pairs back into DFT bins for the inverse direction. Each accepted sample carries a bin index `k`. The index picks a quarter-period twiddle with angle θ = πk/(2N). The sample is multiplied by twice that rotation and rounded back to 24 bits.

In the forward direction the input is the complex bin V(k). The rotated product gives two real coefficients at once: the real part is X(k) and the negated imaginary part is X(N−k). In the inverse direction the input carries the pair X(k) and X(N−k). The unit forms V(k) = X(k) − j·X(N−k) and rotates it by 2·exp(+jθ), ready for the IDFT.

Both directions reduce to the same four products. The direction input only changes how the imaginary input is treated at k = 0. The transform length (512 or 1024) and the direction travel with every sample. A new sample may enter on every clock, and the result appears exactly ten clocks later.

Top module: `dct_rebuild_rotate`

## Requirements
- R1: The twiddle terms come from one table t(i) = round(cos(π·i/2048)·2^17), with i from 0 to 1024 and round meaning floor(x + 0.5). The value 2^17 at i = 0 is clipped to 131071. The cosine term is c = t(i) and the sine term is s = t(1024 − i).
- R2: The table index is i = k when `lenSel` = 1 (N = 1024) and i = 2·k when `lenSel` = 0 (N = 512).
- R3: With `mode` = 0 (forward), a = `inRe` and b = `inIm`, and `outRe` = sat(floor((a·c + b·s + 2^15) / 2^16)). This is the real part of 2·V(k)·exp(−jθ), which is X(k).
- R4: With `mode` = 0, `outIm` = sat(floor((a·s − b·c + 2^15) / 2^16)). This is the negated imaginary part of the rotated product, which is X(N−k).
- R5: With `mode` = 1 (inverse), `inRe` = X(k) and `inIm` = X(N−k). The outputs are the real and imaginary parts of 2·(X(k) − j·X(N−k))·exp(+jθ), which gives the same formulas as R3 and R4 with a = X(k) and b = X(N−k).
- R6: With `mode` = 1 and k = 0, `inIm` is ignored and treated as zero, since X(N) does not exist. With `mode` = 0 and k = 0, `inIm` is used as given.
- R7: Both outputs saturate to the 24-bit two's-complement range [−8388608, 8388607].
- R8: A sample taken with `inValid` high at a rising edge appears with `outValid` high after the 10th rising edge that follows, with `outIdx` equal to its bin index. One sample is accepted per clock, idle cycles are allowed, and `outValid` is never high without a matching input.
- R9: With `lenSel` = 0, bit 9 of `inIdx` is ignored, so the bin index is `inIdx` modulo 512 and `outIdx` bit 9 is 0.
- R10: While `rstN` is low, and after it rises until the first accepted sample comes through, `outValid` is 0.
- R11: `mode` and `lenSel` are sampled with each sample, so successive samples may use different directions and lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample present |
| inIdx | input | 10 | Bin index k |
| inRe | input | 24 | Forward: Re V(k); inverse: X(k) (signed) |
| inIm | input | 24 | Forward: Im V(k); inverse: X(N−k) (signed) |
| mode | input | 1 | 0 forward, 1 inverse |
| lenSel | input | 1 | 0 selects N = 512, 1 selects N = 1024 |
| outValid | output | 1 | Output sample present |
| outIdx | output | 10 | Bin index of the output sample |
| outRe | output | 24 | Forward: X(k); inverse: Re of rotated V(k) (signed) |
| outIm | output | 24 | Forward: X(N−k); inverse: Im of rotated V(k) (signed) |

## Verification
The bench sweeps every bin index for both lengths and both directions. Each result is compared with an integer model of the table and the rounding. A wrong table address, an even/odd stride error or a misplaced rounding offset shows up as a wrong coefficient value ten clocks after the bin that triggered it. A lost or extra valid bit, or a stage that captures data without its enable, shows up as a wrong arrival cycle, a missing sample or a mismatched `outIdx`. Saturation and the k = 0 treatment are driven with extreme values, so a sign or width slip there shows as a wrapped value right at the output.

// File: rtl/dct_rot_pkg.sv
`timescale 1ns/1ps
package dct_rot_pkg;
  // Index width fixes the largest transform (2^IDX_W bins).
  localparam int IDX_W    = 10;
  // Fixed pipeline depth, input register to output register.
  localparam int PIPE_LAT = 10;
  localparam int ADDR_W   = IDX_W + 1;

  // Strobes and addresses handed from control to datapath.
  typedef struct packed {
    logic                killImag; // zero the imaginary input on capture
    logic [ADDR_W-1:0]   cosAddr;  // table index for the cosine term
    logic [ADDR_W-1:0]   sinAddr;  // mirrored index for the sine term
    logic [PIPE_LAT-1:0] stageEn;  // capture enable per pipeline stage
  } rotCtrl_t;
endpackage

// File: rtl/twiddle_rom.sv
`timescale 1ns/1ps
module twiddle_rom #(
  parameter int IDX_BITS = 10,
  parameter int COEF_W   = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdEn,
  input  logic [IDX_BITS:0]        cosAddr,
  input  logic [IDX_BITS:0]        sinAddr,
  output logic signed [COEF_W-1:0] cosQ,
  output logic signed [COEF_W-1:0] sinQ
);
  localparam int  FULL  = 1 << IDX_BITS;
  localparam int  DEPTH = FULL + 1;
  localparam int  CMAX  = (1 << (COEF_W - 1)) - 1;
  localparam real PI_R  = 3.14159265358979323846;
  localparam real SCALE = 2.0 ** (COEF_W - 1);

  logic signed [COEF_W-1:0] quarterCos [DEPTH];

  // cos(pi*i/(2*FULL)) quantised; sine reuses the table mirrored about FULL.
  function automatic logic signed [COEF_W-1:0] quantCos(input int i);
    real ang;
    real v;
    ang = PI_R * real'(i) / (2.0 * real'(FULL));
    v   = $floor($cos(ang) * SCALE + 0.5);
    if (v > real'(CMAX)) v = real'(CMAX);
    return COEF_W'($rtoi(v));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) quarterCos[i] = quantCos(i);
  end

  always_ff @(posedge clk) begin
    if (rdEn) begin
      cosQ <= quarterCos[cosAddr];
      sinQ <= quarterCos[sinAddr];
    end
  end

  // Zero angle must give unity cosine and a null sine.
  p_unity_angle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cosAddr == '0) |=> (cosQ == COEF_W'(CMAX) && sinQ == '0));
endmodule

// File: rtl/rot_ctrl.sv
`timescale 1ns/1ps
module rot_ctrl
  import dct_rot_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIdx,
  input  logic             mode,
  input  logic             lenSel,
  output rotCtrl_t         ctrl,
  output logic             outValid,
  output logic [IDX_W-1:0] outIdx
);
  localparam logic [ADDR_W-1:0] FULL_ADDR = ADDR_W'(1) << IDX_W;

  logic [IDX_W-1:0]    binIdx;
  logic [PIPE_LAT-1:0] vPipe;
  logic [IDX_W-1:0]    idxPipe [PIPE_LAT];
  logic                len1;
  logic [ADDR_W-1:0]   cosAddr;

  // Short transform: top index bit dropped.
  assign binIdx = lenSel ? inIdx : {1'b0, inIdx[IDX_W-2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[PIPE_LAT-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      idxPipe[0] <= binIdx;
      len1       <= lenSel;
    end
    for (int s = 1; s < PIPE_LAT; s++)
      if (vPipe[s-1]) idxPipe[s] <= idxPipe[s-1];
  end

  // Short transform walks the full-resolution table with stride two.
  always_comb begin
    if (len1) cosAddr = {1'b0, idxPipe[0]};
    else      cosAddr = {1'b0, idxPipe[0][IDX_W-2:0], 1'b0};
  end

  always_comb begin
    ctrl.cosAddr  = cosAddr;
    ctrl.sinAddr  = FULL_ADDR - cosAddr;
    ctrl.killImag = inValid & mode & (binIdx == '0);
    ctrl.stageEn  = {vPipe[PIPE_LAT-2:0], inValid};
  end

  assign outValid = vPipe[PIPE_LAT-1];
  assign outIdx   = idxPipe[PIPE_LAT-1];
endmodule

// File: rtl/rot_datapath.sv
`timescale 1ns/1ps
module rot_datapath
  import dct_rot_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rotCtrl_t                 ctrl,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  // Table scale 2^(COEF_W-1); the factor of two removes one more bit.
  localparam int SHIFT  = COEF_W - 2;
  localparam int RND_W  = SUM_W - SHIFT;
  localparam int PAD    = PIPE_LAT - 6;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (SHIFT - 1);
  localparam logic signed [RND_W-1:0] HI   = (RND_W'(1) << (DATA_W - 1)) - RND_W'(1);
  localparam logic signed [RND_W-1:0] LO   = -HI - RND_W'(1);

  logic signed [DATA_W-1:0] aQ, bQ, a2, b2;
  logic signed [COEF_W-1:0] cosQ, sinQ;
  logic signed [PROD_W-1:0] pAC, pBS, pAS, pBC;
  logic signed [SUM_W-1:0]  sumRe, sumIm, tRe, tIm;
  logic signed [RND_W-1:0]  rndRe, rndIm;
  logic signed [DATA_W-1:0] dRe [PAD+1];
  logic signed [DATA_W-1:0] dIm [PAD+1];

  function automatic logic signed [DATA_W-1:0] clip(input logic signed [RND_W-1:0] x);
    if (x > HI)      return DATA_W'(HI);
    else if (x < LO) return DATA_W'(LO);
    else             return DATA_W'(x);
  endfunction

  // Stage 1: capture, with the inverse k=0 imaginary kill.
  always_ff @(posedge clk) begin
    if (ctrl.stageEn[0]) begin
      aQ <= inRe;
      bQ <= ctrl.killImag ? '0 : inIm;
    end
  end

  // Stage 2: table read alongside the data.
  twiddle_rom #(.IDX_BITS(IDX_W), .COEF_W(COEF_W)) u_rom (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (ctrl.stageEn[1]),
    .cosAddr (ctrl.cosAddr),
    .sinAddr (ctrl.sinAddr),
    .cosQ    (cosQ),
    .sinQ    (sinQ)
  );

  always_ff @(posedge clk) begin
    if (ctrl.stageEn[1]) begin
      a2 <= aQ;
      b2 <= bQ;
    end
    // Stage 3: four real products.
    if (ctrl.stageEn[2]) begin
      pAC <= PROD_W'(a2) * PROD_W'(cosQ);
      pBS <= PROD_W'(b2) * PROD_W'(sinQ);
      pAS <= PROD_W'(a2) * PROD_W'(sinQ);
      pBC <= PROD_W'(b2) * PROD_W'(cosQ);
    end
    // Stage 4: combine into real and (negated) imaginary parts.
    if (ctrl.stageEn[3]) begin
      sumRe <= SUM_W'(pAC) + SUM_W'(pBS);
      sumIm <= SUM_W'(pAS) - SUM_W'(pBC);
    end
  end

  assign tRe = sumRe + HALF;
  assign tIm = sumIm + HALF;

  // Stage 5: round half up and drop fraction bits (applies the x2).
  // Stage 6: saturate. Remaining stages only delay to the fixed latency.
  always_ff @(posedge clk) begin
    if (ctrl.stageEn[4]) begin
      rndRe <= tRe[SUM_W-1:SHIFT];
      rndIm <= tIm[SUM_W-1:SHIFT];
    end
    if (ctrl.stageEn[5]) begin
      dRe[0] <= clip(rndRe);
      dIm[0] <= clip(rndIm);
    end
    for (int s = 1; s <= PAD; s++) begin
      if (ctrl.stageEn[5+s]) begin
        dRe[s] <= dRe[s-1];
        dIm[s] <= dIm[s-1];
      end
    end
  end

  assign outRe = dRe[PAD];
  assign outIm = dIm[PAD];

  // Saturation must never flip the sign of the rounded value.
  p_clip_sign_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stageEn[5] |=> (dRe[0][DATA_W-1] == $past(rndRe[RND_W-1]) &&
                         dIm[0][DATA_W-1] == $past(rndIm[RND_W-1])));
endmodule

// File: rtl/dct_rebuild_rotate.sv
`timescale 1ns/1ps
module dct_rebuild_rotate
  import dct_rot_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  input  logic                     mode,
  input  logic                     lenSel,
  output logic                     outValid,
  output logic [IDX_W-1:0]         outIdx,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  localparam int FLY_W = $clog2(PIPE_LAT + 1) + 1;

  rotCtrl_t ctrl;

  rot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inIdx    (inIdx),
    .mode     (mode),
    .lenSel   (lenSel),
    .ctrl     (ctrl),
    .outValid (outValid),
    .outIdx   (outIdx)
  );

  rot_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .inRe  (inRe),
    .inIm  (inIm),
    .outRe (outRe),
    .outIm (outIm)
  );

  // Occupancy seen at the ports, for the checks below.
  logic [FLY_W-1:0] inFlight;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + FLY_W'(inValid) - FLY_W'(outValid);
  end

  p_no_phantom_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight != '0));
  p_flight_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= FLY_W'(PIPE_LAT));
endmodule

// File: tb/dct_rebuild_rotate_bench.sv
`timescale 1ns/1ps
module dct_rebuild_rotate_bench;
  localparam real PI_R = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [9:0] inIdx = '0;
  logic signed [23:0] inRe = '0;
  logic signed [23:0] inIm = '0;
  logic mode = 1'b0;
  logic lenSel = 1'b0;
  logic outValid;
  logic [9:0] outIdx;
  logic signed [23:0] outRe, outIm;

  dct_rebuild_rotate u_dct_rebuild_rotate (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIdx(inIdx), .inRe(inRe),
    .inIm(inIm), .mode(mode), .lenSel(lenSel), .outValid(outValid),
    .outIdx(outIdx), .outRe(outRe), .outIm(outIm)
  );

  always #4 clk = ~clk; // 8 ns period

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  int qIdx[$], qRe[$], qIm[$], qCyc[$];
  string qTag[$];

  always @(posedge clk) cyc <= cyc + 1;

  // R1: quantised quarter cosine table
  function automatic longint tbl(input int i);
    real v;
    v = $floor($cos(PI_R * real'(i) / 2048.0) * 131072.0 + 0.5);
    if (v > 131071.0) v = 131071.0;
    return longint'($rtoi(v));
  endfunction

  function automatic int sat24(input longint x);
    if (x > 64'sd8388607) return 8388607;
    if (x < -64'sd8388608) return -8388608;
    return int'(x);
  endfunction

  function automatic int rnd24();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'({{8{seed[23]}}, seed[23:0]});
  endfunction

  task automatic send(input int k, input int re, input int im, input bit md,
                      input bit ln, input string tag);
    int kk, i;
    longint a, b, c, s;
    kk = ln ? (k & 1023) : (k & 511);           // R9
    i  = ln ? kk : 2 * kk;                      // R2
    c  = tbl(i);
    s  = tbl(1024 - i);                         // R1
    a  = re;
    b  = (md && kk == 0) ? 0 : im;              // R6
    qIdx.push_back(kk);
    qRe.push_back(sat24((a * c + b * s + 32768) >>> 16));  // R3 R5 R7
    qIm.push_back(sat24((a * s - b * c + 32768) >>> 16));  // R4 R5 R7
    qCyc.push_back(cyc);
    qTag.push_back(tag);
    inValid = 1'b1;
    inIdx   = 10'(k);
    inRe    = 24'(re);
    inIm    = 24'(im);
    mode    = md;
    lenSel  = ln;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Output monitor: value, index and arrival cycle (R8).
  int eI, eR, eM, eC;
  string eT;
  always @(negedge clk) begin
    if (rstN && outValid) begin
      nChk++;
      if (qIdx.size() == 0) begin
        nBad++;
        $display("FAIL R8 unexpected output idx=%0d, expected none", outIdx);
      end else begin
        eI = qIdx.pop_front(); eR = qRe.pop_front(); eM = qIm.pop_front();
        eC = qCyc.pop_front(); eT = qTag.pop_front();
        if (int'(outIdx) != eI || int'(outRe) != eR || int'(outIm) != eM ||
            cyc != eC + 10) begin
          nBad++;
          $display("FAIL %s actual idx=%0d re=%0d im=%0d cyc=%0d expected idx=%0d re=%0d im=%0d cyc=%0d",
                   eT, outIdx, outRe, outIm, cyc, eI, eR, eM, eC + 10);
        end
      end
    end
  end

  task automatic checkIdle(input string tag);
    nChk++;
    if (outValid !== 1'b0) begin
      nBad++;
      $display("FAIL %s actual outValid=%b expected 0", tag, outValid);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R10 in reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      checkIdle("R10 after reset");
    end

    // Full sweep, both lengths, direction alternating per bin (R11).
    for (int p = 0; p < 2; p++) begin
      for (int ln = 1; ln >= 0; ln--) begin
        for (int k = 0; k < (ln ? 1024 : 512); k++) begin
          bit md;
          md = bit'((k ^ p) & 1);
          send(k, rnd24(), rnd24(), md, bit'(ln),
               md ? "R1 R2 R5 R11" : "R1 R2 R3 R4 R11");
          if (p == 1 && (k % 7) == 3) @(negedge clk); // idle gap, R8
        end
      end
    end

    // Saturation at both ends (R7).
    send(0, 8388607, 12345, 1'b0, 1'b1, "R7 pos");
    send(0, -8388608, 0, 1'b0, 1'b1, "R7 neg");
    send(0, 8388607, -8388608, 1'b0, 1'b1, "R7 im");
    send(1023, -8388608, 8388607, 1'b0, 1'b1, "R7 k max");
    send(511, 8388607, -8388608, 1'b1, 1'b0, "R7 inv");
    // k=0 imaginary handling (R6).
    send(0, 1000000, 5000000, 1'b1, 1'b1, "R6 inv kill");
    send(0, -77, -8388608, 1'b1, 1'b0, "R6 inv kill 512");
    send(0, 1000000, 5000000, 1'b0, 1'b1, "R6 fwd kept");
    send(512, 3000, 4000000, 1'b1, 1'b0, "R6 R9 aliased zero");
    // Top index bit ignored at N=512 (R9).
    send(512 + 37, 2000000, -1500000, 1'b0, 1'b0, "R9 fwd");
    send(1023, -2000000, 1500000, 1'b1, 1'b0, "R9 inv");

    repeat (15) @(negedge clk);
    nChk++;
    if (qIdx.size() != 0) begin
      nBad++;
      $display("FAIL R8 actual pending=%0d expected 0", qIdx.size());
    end
    checkIdle("R8 drained");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule